// File: doc/BRIEF.md
# Round-Robin Command Slot Issuer

This block decides which of a port's command slots goes to the downstream transfer engine next. Software marks slots as pending through a set-pulse vector. While the port is started, the block finds the next pending slot by rotating priority, presents it with a valid/ready handshake, and keeps it as the current slot until the engine reports that the issue is done. The done report clears that slot's pending bit. A second vector of active-slot flags is held beside the pending vector. The block does not interpret it beyond setting and clearing it.

Priority is not fixed. The search starts from the slot after the last one issued and wraps past the top slot back to slot 0. After every start edge, the first search begins at slot 0 instead. Stopping the port returns the current slot to 0 and empties both vectors. If an issue is in flight when the stop arrives, this happens only after that issue completes.

The controller has four states:
- ST_IDLE: the port is stopped.
- ST_SEARCH: the port is running and no issue is in flight.
- ST_BUSY: a slot has been handed off and the block is waiting for the done report.
- ST_DRAIN: a stop arrived while a slot was in flight, and the block is waiting for that slot to finish.

The transitions are:
- IDLE→SEARCH on start.
- SEARCH→BUSY on an accepted slot.
- SEARCH→IDLE on stop.
- BUSY→SEARCH on done while started.
- BUSY→IDLE on done while stopped.
- BUSY→DRAIN on stop without done.
- DRAIN→IDLE on done.

Top module: `cmd_slot_issuer`

## Requirements
- R1: After reset, `running_o` is 0, `ccs_o` is 0, `ci_o` and `act_o` are all zero, and `slot_valid_o` is 0.
- R2: With the block stopped and `start_i` high at a clock edge, `running_o` is 1 after that edge. The first search after each start treats slot 0 as the highest priority.
- R3: After the first issue, the search begins at `ccs_o`+1 (modulo 32) and moves upward with wrap. With `ccs_o`=0 and pending vector 3h, the slot presented is 1. With `ccs_o`=31 and bits 0 and 4 pending, the slot presented is 0. If `ccs_o`'s own bit is the only pending bit, that slot is presented.
- R4: `slot_valid_o` is 0 whenever the pending vector `ci_o` is all zero.
- R5: When `slot_valid_o` and `slot_ready_i` are both high at an edge, `ccs_o` equals the presented slot after that edge. No further slot is presented until `issue_done_i` arrives, even if new bits are set.
- R6: `issue_done_i` while an issue is in flight clears bit `ccs_o` of `ci_o` at that edge. While the port stays started, it also returns the block to searching.
- R7: `start_i` low with no issue in flight clears `ci_o`, `act_o` and `ccs_o`, and drops `running_o`, at the next edge.
- R8: `start_i` low while an issue is in flight keeps `running_o` high, and `ci_o` and `ccs_o` held, until `issue_done_i`. At that edge the block clears everything as in R7.
- R9: `ci_set_i` and `act_set_i` are ignored while `running_o` is 0, and `ci_o` and `act_o` stay zero.
- R10: After a stop and a new start, the search again begins at slot 0. With pending vector 3h, slot 0 is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Port start control |
| ci_set_i | input | 32 | One-cycle set pulses for pending slots |
| act_set_i | input | 32 | One-cycle set pulses for active-slot flags |
| slot_ready_i | input | 1 | Downstream accepts the presented slot |
| issue_done_i | input | 1 | Downstream has finished the issued slot |
| slot_valid_o | output | 1 | A slot is presented |
| slot_o | output | 5 | Presented slot number |
| ccs_o | output | 5 | Current (last issued) slot |
| running_o | output | 1 | Command list running status |
| ci_o | output | 32 | Pending slot vector |
| act_o | output | 32 | Active-slot flag vector |

## Verification
A wrong current-slot register or start-edge flag would show up as the wrong `slot_o` in the first search after the next issue or start, one cycle after the pending bits settle. A state held in the wrong place would appear at the very next edge in one of three ways: `slot_valid_o` asserted while an issue is still in flight, `running_o` dropping before the done report, or vectors that survive a stop. A missing clear of the pending bit would make the same slot be presented again straight after its done report.

// File: rtl/csi_pkg.sv
package csi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_BUSY,
        ST_DRAIN
    } issue_state_e;
endpackage

// File: rtl/slot_picker.sv
module slot_picker #(
    parameter int NUM_SLOTS = 32,
    localparam int SW = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] pend_i,
    input  logic [SW-1:0]        base_i,
    output logic                 hit_o,
    output logic [SW-1:0]        sel_o
);
    logic [2*NUM_SLOTS-1:0] doubled;
    logic [2*NUM_SLOTS-1:0] shifted;
    logic [NUM_SLOTS-1:0]   rotated;
    logic [SW-1:0]          offset;

    always_comb begin
        doubled = {pend_i, pend_i};
        shifted = doubled >> base_i;
        rotated = shifted[NUM_SLOTS-1:0];
        offset  = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (rotated[i]) offset = SW'(i);
        end
        hit_o = |pend_i;
        sel_o = base_i + offset;
    end
endmodule

// File: rtl/pend_vec.sv
module pend_vec #(
    parameter int NUM_SLOTS = 32,
    localparam int SW = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en_i,
    input  logic [NUM_SLOTS-1:0] ci_set_i,
    input  logic [NUM_SLOTS-1:0] act_set_i,
    input  logic                 clr_bit_i,
    input  logic [SW-1:0]        clr_idx_i,
    input  logic                 clr_all_i,
    output logic [NUM_SLOTS-1:0] ci_o,
    output logic [NUM_SLOTS-1:0] act_o
);
    logic [NUM_SLOTS-1:0] clr_mask;
    logic [NUM_SLOTS-1:0] ci_add;
    logic [NUM_SLOTS-1:0] act_add;

    always_comb begin
        clr_mask = clr_bit_i ? ({{(NUM_SLOTS-1){1'b0}}, 1'b1} << clr_idx_i) : '0;
        ci_add   = set_en_i ? ci_set_i  : '0;
        act_add  = set_en_i ? act_set_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ci_o  <= '0;
            act_o <= '0;
        end else if (clr_all_i) begin
            ci_o  <= '0;
            act_o <= '0;
        end else begin
            ci_o  <= (ci_o | ci_add) & ~clr_mask;
            act_o <= act_o | act_add;
        end
    end
endmodule

// File: rtl/issue_fsm.sv
module issue_fsm #(
    parameter int NUM_SLOTS = 32,
    localparam int SW = $clog2(NUM_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          hit_i,
    input  logic [SW-1:0] sel_i,
    input  logic          ready_i,
    input  logic          done_i,
    output logic          valid_o,
    output logic          running_o,
    output logic [SW-1:0] ccs_o,
    output logic [SW-1:0] base_o,
    output logic          set_en_o,
    output logic          clr_bit_o,
    output logic          clr_all_o
);
    import csi_pkg::*;

    issue_state_e state_q, state_d;
    logic         first_q;
    logic         issue;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_SEARCH;
            ST_SEARCH: begin
                if (!start_i)             state_d = ST_IDLE;
                else if (hit_i && ready_i) state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (done_i)        state_d = start_i ? ST_SEARCH : ST_IDLE;
                else if (!start_i) state_d = ST_DRAIN;
            end
            ST_DRAIN:  if (done_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        valid_o   = 1'b0;
        clr_bit_o = 1'b0;
        clr_all_o = 1'b0;
        running_o = 1'b1;
        unique case (state_q)
            ST_IDLE:   running_o = 1'b0;
            ST_SEARCH: begin
                valid_o   = start_i && hit_i;
                clr_all_o = !start_i;
            end
            ST_BUSY: begin
                clr_bit_o = done_i;
                clr_all_o = done_i && !start_i;
            end
            ST_DRAIN: begin
                clr_bit_o = done_i;
                clr_all_o = done_i;
            end
            default:   running_o = 1'b0;
        endcase
        set_en_o = running_o;
        issue    = valid_o && ready_i;
        base_o   = first_q ? '0 : ccs_o + SW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ccs_o   <= '0;
            first_q <= 1'b1;
        end else begin
            if (clr_all_o)  ccs_o <= '0;
            else if (issue) ccs_o <= sel_i;
            if (state_q == ST_IDLE) first_q <= 1'b1;
            else if (issue)         first_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cmd_slot_issuer.sv
module cmd_slot_issuer #(
    parameter int NUM_SLOTS = 32,
    localparam int SW = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NUM_SLOTS-1:0] ci_set_i,
    input  logic [NUM_SLOTS-1:0] act_set_i,
    input  logic                 slot_ready_i,
    input  logic                 issue_done_i,
    output logic                 slot_valid_o,
    output logic [SW-1:0]        slot_o,
    output logic [SW-1:0]        ccs_o,
    output logic                 running_o,
    output logic [NUM_SLOTS-1:0] ci_o,
    output logic [NUM_SLOTS-1:0] act_o
);
    logic          hit;
    logic [SW-1:0] base;
    logic          set_en;
    logic          clr_bit;
    logic          clr_all;

    slot_picker #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
        .pend_i (ci_o),
        .base_i (base),
        .hit_o  (hit),
        .sel_o  (slot_o)
    );

    pend_vec #(.NUM_SLOTS(NUM_SLOTS)) u_vec (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en_i  (set_en),
        .ci_set_i  (ci_set_i),
        .act_set_i (act_set_i),
        .clr_bit_i (clr_bit),
        .clr_idx_i (ccs_o),
        .clr_all_i (clr_all),
        .ci_o      (ci_o),
        .act_o     (act_o)
    );

    issue_fsm #(.NUM_SLOTS(NUM_SLOTS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .hit_i     (hit),
        .sel_i     (slot_o),
        .ready_i   (slot_ready_i),
        .done_i    (issue_done_i),
        .valid_o   (slot_valid_o),
        .running_o (running_o),
        .ccs_o     (ccs_o),
        .base_o    (base),
        .set_en_o  (set_en),
        .clr_bit_o (clr_bit),
        .clr_all_o (clr_all)
    );
endmodule

// File: rtl/cmd_slot_issuer_chk.sv
module cmd_slot_issuer_chk #(
    parameter int NUM_SLOTS = 32,
    localparam int SW = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic                 slot_ready_i,
    input logic                 slot_valid_o,
    input logic [SW-1:0]        slot_o,
    input logic [SW-1:0]        ccs_o,
    input logic                 running_o,
    input logic [NUM_SLOTS-1:0] ci_o,
    input logic [NUM_SLOTS-1:0] act_o
);
    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !running_o |=> running_o); // R2
    AST_SLOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid_o |-> ci_o[slot_o]); // R3
    AST_NO_EMPTY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (ci_o == '0) |-> !slot_valid_o); // R4
    AST_ISSUE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid_o && slot_ready_i |=> (ccs_o == $past(slot_o)) && !slot_valid_o); // R5
    AST_STOPPED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |-> (ci_o == '0) && (act_o == '0) && (ccs_o == '0)); // R7
endmodule

bind cmd_slot_issuer cmd_slot_issuer_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .slot_ready_i (slot_ready_i),
    .slot_valid_o (slot_valid_o),
    .slot_o       (slot_o),
    .ccs_o        (ccs_o),
    .running_o    (running_o),
    .ci_o         (ci_o),
    .act_o        (act_o)
);

// File: tb/cmd_slot_issuer_test.sv
module cmd_slot_issuer_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;
    localparam int NV = 7;
    // each entry: {bits to set, expected slot, expected pending after done}
    localparam logic [68:0] VEC [NV] = '{
        {32'h0000_0003, 5'd0,  32'h0000_0002},
        {32'h0000_0000, 5'd1,  32'h0000_0000},
        {32'h8000_0001, 5'd31, 32'h0000_0001},
        {32'h0000_0010, 5'd0,  32'h0000_0010},
        {32'h0000_0004, 5'd2,  32'h0000_0010},
        {32'h0000_0000, 5'd4,  32'h0000_0000},
        {32'h0000_0010, 5'd4,  32'h0000_0000}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [N-1:0] ci_set_i = '0;
    logic [N-1:0] act_set_i = '0;
    logic         slot_ready_i = 1'b0;
    logic         issue_done_i = 1'b0;
    logic         slot_valid_o;
    logic [4:0]   slot_o;
    logic [4:0]   ccs_o;
    logic         running_o;
    logic [N-1:0] ci_o;
    logic [N-1:0] act_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_slot_issuer uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ci_set_i(ci_set_i),
        .act_set_i(act_set_i), .slot_ready_i(slot_ready_i),
        .issue_done_i(issue_done_i), .slot_valid_o(slot_valid_o),
        .slot_o(slot_o), .ccs_o(ccs_o), .running_o(running_o),
        .ci_o(ci_o), .act_o(act_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        chk(!running_o && ccs_o == 0, "R1 running/ccs", {running_o, ccs_o}, 0);
        chk(ci_o == 0 && act_o == 0 && !slot_valid_o, "R1 vectors", ci_o, 0);
        rst_n = 1'b1;
        tick();

        // R9: sets ignored while stopped
        ci_set_i = 32'h5; act_set_i = 32'h3;
        tick();
        ci_set_i = '0; act_set_i = '0;
        chk(ci_o == 0, "R9 ci ignored", ci_o, 0);
        chk(act_o == 0, "R9 act ignored", act_o, 0);

        start_i = 1'b1;
        tick();
        chk(running_o, "R2 running", running_o, 1);
        chk(!slot_valid_o, "R4 empty no valid", slot_valid_o, 0);

        for (int i = 0; i < NV; i++) begin
            ci_set_i = VEC[i][68:37];
            tick();
            ci_set_i = '0;
            chk(slot_valid_o && slot_o == VEC[i][36:32], $sformatf("R3 entry %0d slot", i),
                {slot_valid_o, slot_o}, {1'b1, VEC[i][36:32]});
            slot_ready_i = 1'b1;
            tick();
            slot_ready_i = 1'b0;
            chk(ccs_o == VEC[i][36:32] && !slot_valid_o, $sformatf("R5 entry %0d latch", i),
                {slot_valid_o, ccs_o}, {1'b0, VEC[i][36:32]});
            issue_done_i = 1'b1;
            tick();
            issue_done_i = 1'b0;
            chk(ci_o == VEC[i][31:0], $sformatf("R6 entry %0d clear", i), ci_o, VEC[i][31:0]);
        end
        chk(!slot_valid_o, "R4 drained no valid", slot_valid_o, 0);

        // R5: no new slot while in flight; R8: stop while in flight
        act_set_i = 32'hF0;
        ci_set_i = 32'h100;
        tick();
        act_set_i = '0; ci_set_i = '0;
        chk(slot_valid_o && slot_o == 8, "R3 slot 8", slot_o, 8);
        slot_ready_i = 1'b1;
        tick();
        slot_ready_i = 1'b0;
        ci_set_i = 32'h200;
        tick();
        ci_set_i = '0;
        chk(!slot_valid_o && ci_o == 32'h300, "R5 hold while busy", {slot_valid_o, ci_o}, 32'h300);
        start_i = 1'b0;
        tick();
        tick();
        chk(running_o && ccs_o == 8 && ci_o == 32'h300, "R8 drain hold",
            {running_o, ccs_o, ci_o}, {1'b1, 5'd8, 32'h300});
        issue_done_i = 1'b1;
        tick();
        issue_done_i = 1'b0;
        chk(!running_o && ci_o == 0 && act_o == 0 && ccs_o == 0, "R8 cleared after done",
            {running_o, ccs_o, act_o, ci_o}, 0);

        // R10: restart begins at slot 0
        start_i = 1'b1;
        tick();
        ci_set_i = 32'h3;
        act_set_i = 32'h1;
        tick();
        ci_set_i = '0; act_set_i = '0;
        chk(slot_valid_o && slot_o == 0, "R10 restart slot 0", slot_o, 0);

        // R7: stop without in-flight issue
        start_i = 1'b0;
        tick();
        chk(!running_o && ci_o == 0 && act_o == 0 && ccs_o == 0, "R7 idle stop",
            {running_o, ccs_o, act_o, ci_o}, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule